// File: doc/BRIEF.md
# Clock Output Enable Gating

This block decides, for every clock output of a clock generator, whether the output buffer should be running. It merges four sources of control: a per-output enable bit taken from the configuration registers, two active-low clock-request inputs, separate stop inputs for the CPU and PCI output groups, and a global power-down level. The two request inputs can each be mapped through a 3-bit register field onto any one of the differential SRC outputs. A select strap can instead turn the shared request pins into the SRC6 output pair. When that happens the request function is unused.

The combined enable of each output passes through its own synchronizer. It is then committed only while that output's clock is in its low phase, so no output produces a truncated pulse. For each output the block also reports the required disabled state: a disabled differential output goes to tri-state, and a disabled single-ended output is driven low.

Output slots, lowest first:
- Slots 0..6 are SRC1..SRC7.
- Slots 7..8 are CPU0..CPU1.
- Slots 9..14 are the PCI group.
- Slots 15..18 are the fixed outputs. Slot 15 is the differential 96 MHz dot clock.

Top module: `cg_out_gate`

## Requirements
- R1: An output whose register enable bit is 0 is disabled, whatever the other controls. The bits are packed into the slot order above: SRC bit i is slot i, CPU bit i is slot 7+i, PCI bit i is slot 9+i, and fixed bit i is slot 15+i.
- R2: When the strap is 0 and a request input is high (deasserted), the SRC output selected by its 3-bit map field is disabled. A map value k in 1..7 selects SRCk (slot k-1).
- R3: A map value of 0 leaves its request pin unassigned, so the level of that pin affects no output. A low (asserted) request never disables anything.
- R4: When the strap is 1, both request inputs and both map fields are ignored. SRC6 then follows its register bit.
- R5: When the strap is 0, SRC6 (slot 5) is always disabled, because its pins serve as request inputs.
- R6: When the CPU stop input is low, CPU0 and CPU1 are disabled. No other output is affected.
- R7: When the PCI stop input is low, all six PCI slots are disabled. No other output is affected.
- R8: When power down is high, every output is disabled.
- R9: With every low-phase strobe held high, a change of the inputs appears on out_en at the third rising clock edge (two synchronizer stages plus the commit register).
- R10: An out_en bit changes only at an edge where its own out_low strobe was 1. Other slots are unaffected by that strobe.
- R11: out_tri is 1 exactly for disabled differential slots (SRC, CPU and slot 15). It is always 0 for single-ended slots.
- R12: During reset, every out_en is 0 and out_tri equals the differential slot mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| src_en_reg | input | 7 | Enable bits for SRC1..SRC7 |
| cpu_en_reg | input | 2 | Enable bits for CPU0..CPU1 |
| pci_en_reg | input | 6 | Enable bits for the PCI group |
| fix_en_reg | input | 4 | Enable bits for the fixed outputs |
| req_map_a | input | 3 | SRC selected by request A (0 = none) |
| req_map_b | input | 3 | SRC selected by request B (0 = none) |
| req_a_n | input | 1 | Clock request A, active low |
| req_b_n | input | 1 | Clock request B, active low |
| req_sel_strap | input | 1 | 1 = shared pins drive SRC6, 0 = request pins |
| cpu_stop_n | input | 1 | CPU group stop, active low |
| pci_stop_n | input | 1 | PCI group stop, active low |
| pwr_down | input | 1 | Power down, active high |
| out_low | input | 19 | Per-slot low-phase strobe |
| out_en | output | 19 | Final per-slot enable |
| out_tri | output | 19 | Per-slot tri-state flag |

## Verification
The bench builds the block with its default sizes: seven SRC slots, two CPU, six PCI and four fixed slots, two synchronizer stages, and SRC6 as the shared slot. At this size every combination of strap, both 3-bit map fields and both request levels is swept. Each control and every register bit is also toggled on its own. Together these cover the unassigned map value, both pins mapped onto one SRC, and mappings onto SRC6. Low-phase holding is exercised with strobes given to only some of the slots.

// File: rtl/cg_pkg.sv
package cg_pkg;
  // true when a request map value selects SRC slot index slot (value = slot+1)
  function automatic logic map_hits(input logic [7:0] sel, input int unsigned slot);
    return sel == 8'(slot + 1);
  endfunction

  // required tri-state flag of a slot given its enable and whether it is differential
  function automatic logic tri_flag(input logic en, input logic diff);
    return diff & ~en;
  endfunction
endpackage

// File: rtl/cg_req_decode.sv
module cg_req_decode #(
  parameter int NUM_SRC    = 7,
  parameter int MAP_W      = 3,
  parameter int SHARED_SRC = 6
) (
  input  logic [MAP_W-1:0]   map_a,
  input  logic [MAP_W-1:0]   map_b,
  input  logic               req_a_n,
  input  logic               req_b_n,
  input  logic               strap,
  output logic [NUM_SRC-1:0] src_block
);
  import cg_pkg::*;

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
    logic hit_a, hit_b, shared_lost;
    assign hit_a       = req_a_n && map_hits(8'(map_a), i);
    assign hit_b       = req_b_n && map_hits(8'(map_b), i);
    assign shared_lost = (i == SHARED_SRC - 1);
    assign src_block[i] = !strap && (hit_a || hit_b || shared_lost);
  end
endmodule

// File: rtl/cg_gate_combine.sv
module cg_gate_combine #(
  parameter int NUM_SRC = 7,
  parameter int NUM_CPU = 2,
  parameter int NUM_PCI = 6,
  parameter int NUM_FIX = 4,
  localparam int N_OUT   = NUM_SRC + NUM_CPU + NUM_PCI + NUM_FIX,
  localparam int CPU_LO  = NUM_SRC,
  localparam int PCI_LO  = NUM_SRC + NUM_CPU,
  localparam int FIX_LO  = PCI_LO + NUM_PCI
) (
  input  logic [N_OUT-1:0]   reg_en,
  input  logic [NUM_SRC-1:0] src_block,
  input  logic               cpu_stop_n,
  input  logic               pci_stop_n,
  input  logic               pwr_down,
  output logic [N_OUT-1:0]   raw_en
);
  for (genvar i = 0; i < N_OUT; i++) begin : g_slot
    logic gate;
    if (i < CPU_LO) begin : g_src
      assign gate = !src_block[i];
    end else if (i < PCI_LO) begin : g_cpu
      assign gate = cpu_stop_n;
    end else if (i < FIX_LO) begin : g_pci
      assign gate = pci_stop_n;
    end else begin : g_fix
      assign gate = 1'b1;
    end
    assign raw_en[i] = reg_en[i] && gate && !pwr_down;
  end
endmodule

// File: rtl/cg_sync_slot.sv
module cg_sync_slot #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  input  logic low,
  output logic q
);
  logic [SYNC_STAGES-1:0] stage;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage <= '0;
      q     <= 1'b0;
    end else begin
      stage <= {stage[SYNC_STAGES-2:0], d};
      if (low) q <= stage[SYNC_STAGES-1];
    end
  end

  // R10: the committed enable moves only after a low-phase strobe
  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !low |=> $stable(q));
endmodule

// File: rtl/cg_out_gate.sv
module cg_out_gate #(
  parameter int NUM_SRC     = 7,
  parameter int NUM_CPU     = 2,
  parameter int NUM_PCI     = 6,
  parameter int NUM_FIX     = 4,
  parameter int SYNC_STAGES = 2,
  parameter int SHARED_SRC  = 6,
  parameter logic [NUM_FIX-1:0] FIX_DIFF_MASK = 1,
  localparam int MAP_W  = $clog2(NUM_SRC + 1),
  localparam int N_OUT  = NUM_SRC + NUM_CPU + NUM_PCI + NUM_FIX,
  localparam int CPU_LO = NUM_SRC,
  localparam int PCI_LO = NUM_SRC + NUM_CPU,
  localparam int FIX_LO = PCI_LO + NUM_PCI
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] src_en_reg,
  input  logic [NUM_CPU-1:0] cpu_en_reg,
  input  logic [NUM_PCI-1:0] pci_en_reg,
  input  logic [NUM_FIX-1:0] fix_en_reg,
  input  logic [MAP_W-1:0]   req_map_a,
  input  logic [MAP_W-1:0]   req_map_b,
  input  logic               req_a_n,
  input  logic               req_b_n,
  input  logic               req_sel_strap,
  input  logic               cpu_stop_n,
  input  logic               pci_stop_n,
  input  logic               pwr_down,
  input  logic [N_OUT-1:0]   out_low,
  output logic [N_OUT-1:0]   out_en,
  output logic [N_OUT-1:0]   out_tri
);
  import cg_pkg::*;

  localparam logic [N_OUT-1:0] DIFF_MASK =
    {FIX_DIFF_MASK, {NUM_PCI{1'b0}}, {(NUM_SRC + NUM_CPU){1'b1}}};

  logic [N_OUT-1:0]   reg_en;
  logic [NUM_SRC-1:0] src_block;
  logic [N_OUT-1:0]   raw_en;

  assign reg_en = {fix_en_reg, pci_en_reg, cpu_en_reg, src_en_reg};

  cg_req_decode #(
    .NUM_SRC(NUM_SRC), .MAP_W(MAP_W), .SHARED_SRC(SHARED_SRC)
  ) u_dec (
    .map_a(req_map_a), .map_b(req_map_b),
    .req_a_n(req_a_n), .req_b_n(req_b_n),
    .strap(req_sel_strap), .src_block(src_block)
  );

  cg_gate_combine #(
    .NUM_SRC(NUM_SRC), .NUM_CPU(NUM_CPU), .NUM_PCI(NUM_PCI), .NUM_FIX(NUM_FIX)
  ) u_comb (
    .reg_en(reg_en), .src_block(src_block),
    .cpu_stop_n(cpu_stop_n), .pci_stop_n(pci_stop_n),
    .pwr_down(pwr_down), .raw_en(raw_en)
  );

  for (genvar i = 0; i < N_OUT; i++) begin : g_out
    cg_sync_slot #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .d(raw_en[i]), .low(out_low[i]), .q(out_en[i])
    );
    assign out_tri[i] = tri_flag(out_en[i], DIFF_MASK[i]);
  end

  // R1: a cleared register bit never yields a raw enable
  p_reg_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (raw_en & ~reg_en) == '0);

  // R8: power down blocks every slot
  p_pd_r8: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_down |-> raw_en == '0);

  // R5: shared slot is lost while its pins act as request inputs
  p_shared_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !req_sel_strap |-> !raw_en[SHARED_SRC-1]);

  // R6: CPU stop clears the CPU group
  p_cpu_stop_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !cpu_stop_n |-> raw_en[PCI_LO-1:CPU_LO] == '0);

  // R7: PCI stop clears the PCI group
  p_pci_stop_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !pci_stop_n |-> raw_en[FIX_LO-1:PCI_LO] == '0);

  // R11: no slot is both enabled and tri-stated
  p_tri_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (out_en & out_tri) == '0);

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_req_chk
    // R2: a deasserted, mapped request removes its SRC
    p_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (!req_sel_strap && req_a_n && req_map_a == MAP_W'(i + 1)) |-> !raw_en[i]);
  end
endmodule

// File: tb/sim_cg_out_gate.sv
module sim_cg_out_gate;
  localparam int NO = 19;
  localparam logic [NO-1:0] DIFF = 19'h081FF; // slots 0..8 and 15

  logic clk = 0, rst_n = 0;
  logic [6:0] src_en; logic [1:0] cpu_en; logic [5:0] pci_en; logic [3:0] fix_en;
  logic [2:0] map_a, map_b;
  logic ra_n, rb_n, strap, cstop_n, pstop_n, pd;
  logic [NO-1:0] low, en, tri_o;
  int vecs = 0, bad = 0;

  always #10 clk = ~clk;

  cg_out_gate u0 (
    .clk(clk), .rst_n(rst_n), .src_en_reg(src_en), .cpu_en_reg(cpu_en),
    .pci_en_reg(pci_en), .fix_en_reg(fix_en), .req_map_a(map_a), .req_map_b(map_b),
    .req_a_n(ra_n), .req_b_n(rb_n), .req_sel_strap(strap), .cpu_stop_n(cstop_n),
    .pci_stop_n(pstop_n), .pwr_down(pd), .out_low(low), .out_en(en), .out_tri(tri_o)
  );

  function automatic logic [NO-1:0] model();
    logic [NO-1:0] e;
    e = {fix_en, pci_en, cpu_en, src_en};
    if (!strap) begin
      e[5] = 1'b0;
      if (ra_n && map_a != 0) e[map_a - 1] = 1'b0;
      if (rb_n && map_b != 0) e[map_b - 1] = 1'b0;
    end
    if (!cstop_n) e[8:7] = 2'b00;
    if (!pstop_n) e[14:9] = 6'b0;
    if (pd) e = '0;
    return e;
  endfunction

  task automatic check(input string req, input logic [NO-1:0] exp_en);
    logic [NO-1:0] exp_tri;
    exp_tri = DIFF & ~exp_en;
    vecs++;
    if (en !== exp_en || tri_o !== exp_tri) begin
      bad++;
      $display("FAIL %s en=%h exp %h tri=%h exp %h", req, en, exp_en, tri_o, exp_tri);
    end
  endtask

  task automatic settle();  // R9: three edges, then sample at negedge
    repeat (3) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic defaults();
    src_en = '1; cpu_en = '1; pci_en = '1; fix_en = '1;
    map_a = 0; map_b = 0; ra_n = 0; rb_n = 0; strap = 1;
    cstop_n = 1; pstop_n = 1; pd = 0; low = '1;
  endtask

  initial begin
    #(20 * 100000);
    bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
    $finish;
  end

  initial begin
    logic [NO-1:0] prev, nxt;
    defaults();
    repeat (3) @(negedge clk);
    check("R12 reset", '0);
    rst_n = 1;
    settle();
    check("R9 first enable", '1);

    // R2 R3 R4 R5: full sweep of strap, maps and request levels
    for (int v = 0; v < 512; v++) begin
      strap = v[8]; map_a = v[7:5]; map_b = v[4:2]; ra_n = v[1]; rb_n = v[0];
      src_en = (v % 3 == 0) ? 7'(v * 53 + 7) : 7'h7F;
      settle();
      check(strap ? "R4 strap" : (map_a == 0 || map_b == 0) ? "R3 unmapped" : "R2 R5 request", model());
    end

    // R6 R7 R8: stop and power-down combinations
    defaults();
    for (int v = 0; v < 8; v++) begin
      cstop_n = v[0]; pstop_n = v[1]; pd = v[2];
      settle();
      check(pd ? "R8 power down" : "R6 R7 stops", model());
    end

    // R1 R11: walk a zero through every register bit
    for (int s = 0; s < NO; s++) begin
      logic [NO-1:0] r;
      defaults();
      r = '1; r[s] = 1'b0;
      {fix_en, pci_en, cpu_en, src_en} = r;
      settle();
      check("R1 R11 reg bit", model());
    end

    // R9: exact latency, output still old after two edges
    defaults();
    settle();
    prev = model();
    pd = 1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    check("R9 not yet", prev);
    @(posedge clk); @(negedge clk);
    check("R9 third edge", '0);

    // R10: strobes to even slots only
    pd = 0;
    low = '0;
    repeat (5) @(posedge clk);
    @(negedge clk);
    check("R10 held", '0);
    for (int i = 0; i < NO; i += 2) low[i] = 1'b1;
    @(posedge clk); @(negedge clk);
    nxt = '0;
    for (int i = 0; i < NO; i += 2) nxt[i] = 1'b1;
    check("R10 partial", nxt);
    low = '1;
    @(posedge clk); @(negedge clk);
    check("R10 rest", model());

    $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
    $finish;
  end
endmodule